// File: doc/BRIEF.md
# Convolution Row Cache

This block sits in front of a small-tile fast-convolution engine. Feature-map pixels arrive as a valid/ready stream, one image row at a time. Within a row the channels are interleaved, so every column delivers all of its channels before the next column starts. The block keeps N complete rows in a ring of N+1 row slots. The extra slot accepts the next row while tiles are still being read from the others.

From the N held rows the block produces square N×N tiles. Each tile goes out as one wide word per channel. At a given tile position every channel is emitted in turn. The position then steps right by M columns, so neighbouring tiles share N−M columns that come from the cache and are not fetched again. When the rightmost position of a tile row has been emitted, the M oldest rows are freed and the window moves down by M rows. The convolution stride is always 1.

Parameters are the pixel width DW, the row width ROW_W in columns, the channel count CH, the tile size N and the tile step M. They must satisfy M < N ≤ ROW_W, and ROW_W−N must be a multiple of M.

Top module: `conv_row_cache`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0 and in_ready is 1. A reset in the middle of a run discards all stored rows, and the next row accepted becomes the top row of the window.
- R2: Input beat k of a row (counting from 0) holds column k/CH, channel k%CH. A row is complete after ROW_W*CH accepted beats.
- R3: out_valid stays 0 until N complete rows are held. It becomes 1 within three cycles after the beat that completes the N-th row.
- R4: Tile element (r,c) sits at out_tile bits [(r*N+c)*DW +: DW]. It holds the pixel at window row r (row 0 is the oldest), column out_x+c, channel out_chan.
- R5: At each tile position, tiles go out for channels 0 up to CH−1 in order. out_x then advances by M, running from 0 to ROW_W−N.
- R6: After the channel CH−1 tile at the last position is accepted, the next tile starts again at out_x 0 with its top row M image rows lower.
- R7: in_ready is 0 whenever all N+1 row slots hold complete rows that have not yet been freed.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_tile, out_chan and out_x keep their values.
- R9: Loading a row overlaps with readout. in_ready is 1 as soon as a slot is free, including the cycle after a window move frees rows, and input is accepted while tiles are still being delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_data | input | DW | Input pixel, channel-interleaved row order |
| out_valid | output | 1 | Tile word valid |
| out_ready | input | 1 | Consumer accepts the tile word |
| out_tile | output | N*N*DW | N×N tile of one channel |
| out_chan | output | max(1,clog2(CH)) | Channel of the tile |
| out_x | output | max(1,clog2(ROW_W)) | Left column of the tile |

## Verification
The assertions expect reset to be applied at the start. They also expect the parameters to satisfy M < N ≤ ROW_W with ROW_W−N a multiple of M, because the ring and column arithmetic depend on that. Beyond those two points they assume nothing about the consumer, which may drop or raise out_ready on any cycle. The stimulus drives every input at the falling clock edge and keeps in_data steady until the beat is accepted. It also holds out_ready low for several cycles on selected tiles, so that holding a tile and back-pressuring the input are both exercised within those limits.

// File: rtl/crc_pkg.sv
package crc_pkg;
  // Width for a counter or index over x values, never below one bit.
  function automatic int bits_for(input int x);
    return (x <= 2) ? 1 : $clog2(x);
  endfunction
endpackage

// File: rtl/crc_fill_ctrl.sv
module crc_fill_ctrl import crc_pkg::*; #(
  parameter int ROW_W = 8,
  parameter int CH    = 2,
  parameter int N     = 4,
  parameter int M     = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          release_rows,
  output logic                          wr_en,
  output logic [bits_for(N+1)-1:0]      wr_slot,
  output logic [bits_for(ROW_W*CH)-1:0] wr_idx,
  output logic [bits_for(N+2)-1:0]      full_rows
);
  localparam int NR   = N + 1;
  localparam int RW   = ROW_W * CH;
  localparam int SLW  = bits_for(NR);
  localparam int IW   = bits_for(RW);
  localparam int CNTW = bits_for(N + 2);

  logic            row_done;
  logic [CNTW-1:0] full_n;

  assign in_ready = (int'(full_rows) < NR);
  assign wr_en    = in_valid && in_ready;
  assign row_done = wr_en && (wr_idx == IW'(RW - 1));

  always_comb begin
    full_n = full_rows;
    if (row_done)     full_n = full_n + 1'b1;
    if (release_rows) full_n = full_n - CNTW'(M);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_slot   <= '0;
      wr_idx    <= '0;
      full_rows <= '0;
    end else begin
      full_rows <= full_n;
      if (wr_en) begin
        if (row_done) begin
          wr_idx  <= '0;
          wr_slot <= (wr_slot == SLW'(NR - 1)) ? '0 : wr_slot + 1'b1;
        end else begin
          wr_idx <= wr_idx + 1'b1;
        end
      end
    end
  end

  // Slot count never exceeds the ring size.
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    int'(full_rows) <= NR);

  // Row count only moves on a completed row or a window move.
  assert_row_step_R2: assert property (@(posedge clk) disable iff (rst)
    (full_rows != $past(full_rows)) |-> ($past(row_done) || $past(release_rows)));
endmodule

// File: rtl/crc_tile_seq.sv
module crc_tile_seq import crc_pkg::*; #(
  parameter int ROW_W = 8,
  parameter int CH    = 2,
  parameter int N     = 4,
  parameter int M     = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 adv,
  output logic                                 release_rows,
  output logic [bits_for(N+1)-1:0]             base_slot,
  output logic [bits_for((ROW_W-N)/M+1)-1:0]   tcol,
  output logic [bits_for(CH)-1:0]              chan
);
  localparam int NR    = N + 1;
  localparam int SLW   = bits_for(NR);
  localparam int TCOLS = (ROW_W - N) / M + 1;
  localparam int TCW   = bits_for(TCOLS);
  localparam int CHW   = bits_for(CH);

  logic           last_ch, last_col;
  logic [SLW:0]   bsum;
  logic [SLW-1:0] next_base;

  assign last_ch      = (chan == CHW'(CH - 1));
  assign last_col     = (tcol == TCW'(TCOLS - 1));
  assign release_rows = adv && last_ch && last_col;
  assign bsum         = {1'b0, base_slot} + (SLW+1)'(M);
  assign next_base    = (int'(bsum) >= NR) ? SLW'(int'(bsum) - NR) : bsum[SLW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      chan      <= '0;
      tcol      <= '0;
      base_slot <= '0;
    end else if (adv) begin
      if (!last_ch) begin
        chan <= chan + 1'b1;
      end else begin
        chan <= '0;
        if (last_col) begin
          tcol      <= '0;
          base_slot <= next_base;
        end else begin
          tcol <= tcol + 1'b1;
        end
      end
    end
  end

  // A window move shifts the oldest slot by M around the ring.
  assert_window_step_R6: assert property (@(posedge clk) disable iff (rst)
    release_rows |=> (int'(base_slot) == (int'($past(base_slot)) + M) % NR));
endmodule

// File: rtl/crc_store.sv
module crc_store import crc_pkg::*; #(
  parameter int DW    = 8,
  parameter int ROW_W = 8,
  parameter int CH    = 2,
  parameter int N     = 4,
  parameter int M     = 2
) (
  input  logic                                 clk,
  input  logic                                 wr_en,
  input  logic [bits_for(N+1)-1:0]             wr_slot,
  input  logic [bits_for(ROW_W*CH)-1:0]        wr_idx,
  input  logic [DW-1:0]                        wr_data,
  input  logic [bits_for(N+1)-1:0]             base_slot,
  input  logic [bits_for((ROW_W-N)/M+1)-1:0]   tcol,
  input  logic [bits_for(CH)-1:0]              chan,
  output logic [N*N*DW-1:0]                    tile
);
  localparam int NR    = N + 1;
  localparam int RW    = ROW_W * CH;
  localparam int DEPTH = NR * RW;
  localparam int SLW   = bits_for(NR);
  localparam int AW    = bits_for(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] waddr;

  assign waddr = AW'(wr_slot) * AW'(RW) + AW'(wr_idx);

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wr_data;
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    logic [SLW:0]   sum;
    logic [SLW-1:0] slot;
    assign sum  = {1'b0, base_slot} + (SLW+1)'(r);
    assign slot = (int'(sum) >= NR) ? SLW'(int'(sum) - NR) : sum[SLW-1:0];
    for (genvar c = 0; c < N; c++) begin : g_col
      logic [AW-1:0] raddr;
      assign raddr = AW'(slot) * AW'(RW)
                   + (AW'(tcol) * AW'(M) + AW'(c)) * AW'(CH) + AW'(chan);
      assign tile[(r*N+c)*DW +: DW] = mem[raddr];
    end
  end
endmodule

// File: rtl/conv_row_cache.sv
module conv_row_cache import crc_pkg::*; #(
  parameter int DW    = 8,
  parameter int ROW_W = 8,
  parameter int CH    = 2,
  parameter int N     = 4,
  parameter int M     = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DW-1:0]              in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [N*N*DW-1:0]          out_tile,
  output logic [bits_for(CH)-1:0]    out_chan,
  output logic [bits_for(ROW_W)-1:0] out_x
);
  localparam int NR    = N + 1;
  localparam int SLW   = bits_for(NR);
  localparam int IW    = bits_for(ROW_W * CH);
  localparam int CNTW  = bits_for(N + 2);
  localparam int TCW   = bits_for((ROW_W - N) / M + 1);
  localparam int CHW   = bits_for(CH);
  localparam int XW    = bits_for(ROW_W);

  logic            wr_en, release_rows, rows_ok, adv;
  logic [SLW-1:0]  wr_slot, base_slot;
  logic [IW-1:0]   wr_idx;
  logic [CNTW-1:0] full_rows;
  logic [TCW-1:0]  tcol;
  logic [CHW-1:0]  chan;
  logic [N*N*DW-1:0] tile;

  assign rows_ok = (int'(full_rows) >= N);
  assign adv     = rows_ok && (!out_valid || out_ready);

  crc_fill_ctrl #(.ROW_W(ROW_W), .CH(CH), .N(N), .M(M)) fill_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .release_rows(release_rows), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_idx(wr_idx), .full_rows(full_rows));

  crc_tile_seq #(.ROW_W(ROW_W), .CH(CH), .N(N), .M(M)) seq_i (
    .clk(clk), .rst(rst), .adv(adv), .release_rows(release_rows),
    .base_slot(base_slot), .tcol(tcol), .chan(chan));

  crc_store #(.DW(DW), .ROW_W(ROW_W), .CH(CH), .N(N), .M(M)) store_i (
    .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
    .wr_data(in_data), .base_slot(base_slot), .tcol(tcol), .chan(chan),
    .tile(tile));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_tile  <= '0;
      out_chan  <= '0;
      out_x     <= '0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_tile  <= tile;
      out_chan  <= chan;
      out_x     <= XW'(tcol) * XW'(M);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_tile_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tile)
                                   && $stable(out_chan) && $stable(out_x)));

  assert_chan_order_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid && out_ready) && ($past(out_chan) != CHW'(CH - 1)))
      |-> (out_chan == $past(out_chan) + 1'b1));

  assert_window_full_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (int'($past(full_rows)) >= N));
endmodule

// File: tb/conv_row_cache_tb_top.sv
`timescale 1ns/1ps
module conv_row_cache_tb_top;
  localparam int DW = 8, ROW_W = 8, CH = 2, N = 4, M = 2;
  localparam int RW = ROW_W * CH;
  localparam int TW = N * N * DW;
  localparam int NV = 18;
  // Expected tile sequence: window top row, left column, channel, stall cycles.
  localparam int VEC_TOP  [NV] = '{0,0,0,0,0,0, 2,2,2,2,2,2, 4,4,4,4,4,4};
  localparam int VEC_X    [NV] = '{0,0,2,2,4,4, 0,0,2,2,4,4, 0,0,2,2,4,4};
  localparam int VEC_CH   [NV] = '{0,1,0,1,0,1, 0,1,0,1,0,1, 0,1,0,1,0,1};
  localparam int VEC_WAIT [NV] = '{3,0,0,2,0,0, 0,1,0,0,0,4, 0,0,0,0,2,0};

  logic clk = 1'b0;
  logic rst, in_valid, in_ready, out_valid, out_ready;
  logic [DW-1:0] in_data;
  logic [TW-1:0] out_tile;
  logic [0:0]    out_chan;
  logic [2:0]    out_x;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  conv_row_cache #(.DW(DW), .ROW_W(ROW_W), .CH(CH), .N(N), .M(M)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_tile(out_tile), .out_chan(out_chan), .out_x(out_x));

  function automatic logic [DW-1:0] pix(input int row, input int col, input int ch);
    return DW'(row * 16 + col * 2 + ch);
  endfunction

  function automatic logic [TW-1:0] exp_tile(input int top, input int x, input int ch);
    logic [TW-1:0] t;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        t[(r*N+c)*DW +: DW] = pix(top + r, x + c, ch);
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input logic [TW-1:0] act,
                       input logic [TW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2: beat k carries column k/CH, channel k%CH.
  task automatic send_row(input int r);
    for (int k = 0; k < RW; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pix(r, k / CH, k % CH);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take_beat(input int k);
    logic [TW-1:0] snap;
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    if (VEC_WAIT[k] > 0) begin
      snap = out_tile;
      repeat (VEC_WAIT[k]) @(negedge clk);
      check(out_valid && out_tile == snap, "R8 hold", out_tile, snap);
    end
    check(out_tile == exp_tile(VEC_TOP[k], VEC_X[k], VEC_CH[k]),
          (k >= 6) ? "R6 tile after window move" : "R4 tile content",
          out_tile, exp_tile(VEC_TOP[k], VEC_X[k], VEC_CH[k]));
    check(int'(out_chan) == VEC_CH[k] && int'(out_x) == VEC_X[k], "R5 order",
          TW'({out_chan, out_x}), TW'({1'(VEC_CH[k]), 3'(VEC_X[k])}));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    check(!out_valid && in_ready, "R1 during reset", TW'({out_valid, in_ready}), TW'(2'b01));
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after reset", TW'({out_valid, in_ready}), TW'(2'b01));

    for (int r = 0; r < 3; r++) send_row(r);
    repeat (10) @(negedge clk);
    check(!out_valid, "R3 no tile before N rows", TW'(out_valid), TW'(0));
    send_row(3);
    repeat (3) @(negedge clk);
    check(out_valid, "R3 tile after N rows", TW'(out_valid), TW'(1));

    send_row(4);
    repeat (3) @(negedge clk);
    check(!in_ready, "R7 all slots full", TW'(in_ready), TW'(0));

    for (int k = 0; k < 6; k++) take_beat(k);
    check(in_ready, "R9 slot freed after move", TW'(in_ready), TW'(1));

    send_row(5);
    fork
      begin send_row(6); send_row(7); end
      begin for (int k = 6; k < 12; k++) take_beat(k); end
    join
    for (int k = 12; k < NV; k++) take_beat(k);

    // Reset in mid-run with a row partly loaded.
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 mid-run reset", TW'({out_valid, in_ready}), TW'(2'b01));
    for (int r = 8; r < 12; r++) send_row(r);
    repeat (3) @(negedge clk);
    check(out_valid && out_tile == exp_tile(8, 0, 0), "R1 ring restart",
          out_tile, exp_tile(8, 0, 0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule